// File: doc/BRIEF.md
# Per-Pin GPIO Control Bank

This block is a general-purpose I/O controller in which each pin owns one 32-bit control word on a simple word-addressed register port. That word carries the pin's drive value, its direction, its interrupt enable and type, a debounce selection, an input mask and a live view of the synchronized pad level. Each pin connects to a tri-state pad through separate out, output-enable and in signals.

Software can find pending interrupts quickly through a read-only summary region that packs the status flags of 32 pins into each word. The same region also clears flags when 1s are written to it. A single interrupt line is raised while any pin has a pending flag and its enable set. One bit of the control word, bit 6, is kept as a plain stored flag and has no effect on the block.

Top module: `gpio_pin_bank`

## Requirements
- R1: The control word of pin p sits at byte address 0x180 + 4*p. Writable fields are bit 0 (drive value, to `pad_out_o[p]`), bit 1 (direction, 1 enables `pad_oe_o[p]`), bit 2 (interrupt enable), bits 5:3 (interrupt type), bit 6 (stored, no effect), bits 8:7 (debounce code) and bit 9 (input mask). All of these read back as written. Bits 10, 11 and 31:14 always read 0.
- R2: Bit 13 is read-only and returns the pad level after a two-flop synchronizer and the debounce filter. It reflects the pad whether the pin drives or not.
- R3: Read data appears on `rdata_o` in the cycle after a read request and is held until the next read. An access whose address has bits 1:0 not zero, or that hits no mapped word, writes nothing and reads 0.
- R4: Edge interrupts use type bit 3 = 0. With bit 5 = 0, bit 4 = 1 flags rising edges and bit 4 = 0 flags falling edges. With bit 5 = 1, both edges are flagged.
- R5: Level interrupts use type bit 3 = 1. Bit 4 selects a high (1) or low (0) level. While the level holds, the flag sets again even in the cycle it is cleared.
- R6: While bit 9 is set, the input bit 13 is frozen and no interrupt flag is set.
- R7: Bit 12 of the control word is the pin's interrupt flag. Writing 1 to it clears the flag; writing 0 leaves it unchanged.
- R8: Summary word w sits at 0x100 + 4*w. Its bit b mirrors the flag of pin 32*w + b. Writing 1 to a bit clears that flag; writing 0 has no effect.
- R9: Debounce codes 0, 1, 2 and 3 require 1, 2, 4 and 8 consecutive synchronized samples differing from the current input value before bit 13 updates. A shorter pulse is discarded.
- R10: `irq_o` is high exactly while some pin has both its flag and its enable set. Clearing the enable drops the line but keeps the flag.
- R11: After reset every control word and flag is 0, no pad is driven, and `irq_o` and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| pad_in_i | input | NUM_PINS | Pad input levels |
| pad_out_o | output | NUM_PINS | Pad drive values |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle. The pad enables change only after a write. Read data holds between reads. A flag rises only in the cycle after an interrupt event. A masked input never moves. The interrupt line is never high without a pending flag.

Other behaviour can only be shown by the bench's scenarios. These are the exact edge and level selection of each type code, level re-assertion across a clear, and the pulse lengths each debounce code passes or rejects. They also include the packing of a pin beyond 32 into the second summary word.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int CFG_W     = 10;
  localparam int BIT_STS   = 12;
  localparam int BIT_IN    = 13;
  localparam int CTRL_BASE = 'h180;
  localparam int PACK_BASE = 'h100;

  // field order matches the bit layout 9..0 of the control word
  typedef struct packed {
    logic       mask;
    logic [1:0] deb;
    logic       keep;
    logic [2:0] kind;
    logic       ien;
    logic       dir;
    logic       out;
  } pin_cfg_t;

endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pad_i,
  input  logic             hold_i,
  input  logic [DEB_W-1:0] deb_i,
  output logic             lvl_o
);

  localparam int CNT_W = (1 << DEB_W) - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       limit;
  logic                   lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
  end

  assign smp = sync_q[SYNC_STAGES-1];

  // samples needed = 2**code, so counter limit = 2**code - 1
  always_comb limit = CNT_W'((32'd1 << deb_i) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (hold_i || (smp == lvl_q)) begin
      cnt_q <= '0;
    end else if (cnt_q == limit) begin
      cnt_q <= '0;
      lvl_q <= smp;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic       hold_i,
  input  logic       en_i,
  input  logic [2:0] kind_i,
  input  logic       clr_i,
  output logic       evt_o,
  output logic       sts_o
);

  logic prev_q, sts_q, rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    if (kind_i[0])      hit = (lvl_i == kind_i[1]);
    else if (kind_i[2]) hit = rise | fall;
    else if (kind_i[1]) hit = rise;
    else                hit = fall;
  end

  assign evt_o = en_i & ~hold_i & hit;

  // a new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= 1'b0;
    else         sts_q <= (sts_q & ~clr_i) | evt_o;
  end

  assign sts_o = sts_q;

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);

  localparam int WA_W       = ADDR_W - 2;
  localparam int PACK_WORDS = (NUM_PINS + 31) / 32;
  localparam int CTRL_W0    = CTRL_BASE / 4;
  localparam int PACK_W0    = PACK_BASE / 4;

  logic [WA_W-1:0]            wa;
  logic                       acc;
  pin_cfg_t                   cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0]        hit_ctrl, clr, sts_q, evt_w, hold_w, lvl_w, ien_w;
  logic [PACK_WORDS-1:0]      hit_pack;
  logic [PACK_WORDS*32-1:0]   sts_ext;
  logic [31:0]                rd_next, rdata_q;

  assign wa  = addr_i[ADDR_W-1:2];
  assign acc = req_i && (addr_i[1:0] == 2'b00);

  for (genvar w = 0; w < PACK_WORDS; w++) begin : g_pack
    assign hit_pack[w] = acc && (wa == WA_W'(PACK_W0 + w));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign hit_ctrl[p] = acc && (wa == WA_W'(CTRL_W0 + p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cfg_q[p] <= '0;
      else if (we_i && hit_ctrl[p]) cfg_q[p] <= pin_cfg_t'(wdata_i[CFG_W-1:0]);
    end

    assign clr[p] = we_i & ((hit_ctrl[p] & wdata_i[BIT_STS]) |
                            (hit_pack[p/32] & wdata_i[p%32]));

    assign hold_w[p]    = cfg_q[p].mask;
    assign ien_w[p]     = cfg_q[p].ien;
    assign pad_out_o[p] = cfg_q[p].out;
    assign pad_oe_o[p]  = cfg_q[p].dir;

    gpio_in_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_W      (2)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pad_i (pad_in_i[p]),
      .hold_i(hold_w[p]),
      .deb_i (cfg_q[p].deb),
      .lvl_o (lvl_w[p])
    );

    gpio_irq_unit u_irq (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl_w[p]),
      .hold_i(hold_w[p]),
      .en_i  (ien_w[p]),
      .kind_i(cfg_q[p].kind),
      .clr_i (clr[p]),
      .evt_o (evt_w[p]),
      .sts_o (sts_q[p])
    );
  end

  always_comb begin
    sts_ext = '0;
    sts_ext[NUM_PINS-1:0] = sts_q;
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (hit_ctrl[p]) rd_next = rd_next | {18'b0, lvl_w[p], sts_q[p], 2'b00, cfg_q[p]};
    end
    for (int w = 0; w < PACK_WORDS; w++) begin
      if (hit_pack[w]) rd_next = rd_next | sts_ext[w*32 +: 32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rdata_q <= '0;
    else if (acc && !we_i) rdata_q <= rd_next;
    else if (req_i && !we_i) rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(sts_q & ien_w);

endmodule

// File: rtl/gpio_pin_bank_chk.sv
module gpio_pin_bank_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] sts_q,
  input logic [NUM_PINS-1:0] evt_w,
  input logic [NUM_PINS-1:0] hold_w,
  input logic [NUM_PINS-1:0] lvl_w
);

  p_oe_write_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(pad_oe_o));

  p_rdata_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  p_irq_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts_q != '0));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    p_flag_from_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sts_q[p]) |-> $past(evt_w[p]));

    p_mask_freezes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_w[p] && $past(hold_w[p])) |-> $stable(lvl_w[p]));
  end

endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .rdata_o (rdata_o),
  .pad_oe_o(pad_oe_o),
  .irq_o   (irq_o),
  .sts_q   (sts_q),
  .evt_w   (evt_w),
  .hold_w  (hold_w),
  .lvl_w   (lvl_w)
);

// File: tb/sim_gpio_pin_bank.sv
module sim_gpio_pin_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 40;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pad_in_i = '0;
  logic [NP-1:0] pad_out_o, pad_oe_o;
  logic          irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] d, d_prev;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_pin_bank #(.NUM_PINS(NP), .ADDR_W(12)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .irq_o(irq_o)
  );

  typedef struct packed {
    logic [7:0]  pin;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        out;
    logic        oe;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'd0,  32'h0000_0003, 32'h0000_0003, 1'b1, 1'b1},
    '{8'd1,  32'h0000_0002, 32'h0000_0002, 1'b0, 1'b1},
    '{8'd5,  32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0},
    '{8'd7,  32'h0000_03F0, 32'h0000_03F0, 1'b0, 1'b0},
    '{8'd39, 32'hFFFF_EC00, 32'h0000_0000, 1'b0, 1'b0},
    '{8'd12, 32'h0000_0281, 32'h0000_0281, 1'b1, 1'b0},
    '{8'd20, 32'h0000_0046, 32'h0000_0046, 1'b0, 1'b1}
  };

  function automatic logic [11:0] ca(input int p);
    return 12'(32'h180 + 4 * p);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = v;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic pulse(input int p, input int n);
    pad_in_i[p] = 1'b1;
    repeat (n) @(negedge clk_i);
    pad_in_i[p] = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R11 reset state
    chk("R11 pad_oe", 32'(pad_oe_o), 32'h0);
    chk("R11 pad_out", 32'(pad_out_o), 32'h0);
    chk("R11 irq", 32'(irq_o), 32'h0);
    chk("R11 rdata", rdata_o, 32'h0);
    rd(ca(0), d);  chk("R11 pin0 word", d, 32'h0);
    rd(12'h100, d); chk("R11 summary", d, 32'h0);

    // R1 table walk
    for (int i = 0; i < 7; i++) begin
      wr(ca(int'(VECS[i].pin)), VECS[i].wd);
      rd(ca(int'(VECS[i].pin)), d);
      chk($sformatf("R1 readback vec %0d", i), d, VECS[i].exp);
      chk($sformatf("R1 pad_out vec %0d", i), 32'(pad_out_o[VECS[i].pin]), 32'(VECS[i].out));
      chk($sformatf("R1 pad_oe vec %0d", i), 32'(pad_oe_o[VECS[i].pin]), 32'(VECS[i].oe));
    end

    // R2 input sample, both directions
    pad_in_i[0] = 1'b1; idle(5);
    rd(ca(0), d); chk("R2 driving pin sees pad", d, 32'h2003);
    pad_in_i[3] = 1'b1; idle(5);
    rd(ca(3), d); chk("R2 input pin high", d, 32'h2000);
    pad_in_i[3] = 1'b0; idle(5);
    rd(ca(3), d); chk("R2 input pin low", d, 32'h0);

    // R3 hold between reads
    d_prev = rdata_o;
    rd(ca(0), d); idle(3);
    chk("R3 rdata held", rdata_o, 32'h2003);

    // R4 rising
    wr(ca(3), 32'h14);
    pad_in_i[3] = 1'b1; idle(5);
    rd(ca(3), d); chk("R4 rising sets flag", d, 32'h3014);
    chk("R10 irq with pending", 32'(irq_o), 32'h1);
    wr(ca(3), 32'h1014);
    rd(ca(3), d); chk("R7 clear by bit12", d, 32'h2014);
    chk("R10 irq after clear", 32'(irq_o), 32'h0);
    pad_in_i[3] = 1'b0; idle(5);
    rd(ca(3), d); chk("R4 rising ignores fall", d, 32'h14);
    // R4 falling
    wr(ca(3), 32'h04);
    pad_in_i[3] = 1'b1; idle(5);
    rd(ca(3), d); chk("R4 falling ignores rise", d, 32'h2004);
    pad_in_i[3] = 1'b0; idle(5);
    rd(ca(3), d); chk("R4 falling sets flag", d, 32'h1004);
    wr(ca(3), 32'h1004);
    // R4 both
    wr(ca(3), 32'h24);
    pad_in_i[3] = 1'b1; idle(5);
    rd(ca(3), d); chk("R4 both rise", d, 32'h3024);
    wr(ca(3), 32'h1024);
    rd(ca(3), d); chk("R4 both cleared", d, 32'h2024);
    pad_in_i[3] = 1'b0; idle(5);
    rd(ca(3), d); chk("R4 both fall", d, 32'h1024);
    wr(ca(3), 32'h1024);

    // R5 level high with re-assert
    wr(ca(3), 32'h1C);
    pad_in_i[3] = 1'b1; idle(5);
    rd(ca(3), d); chk("R5 level high", d, 32'h301C);
    wr(ca(3), 32'h101C); idle(2);
    rd(ca(3), d); chk("R5 level re-asserts", d, 32'h301C);
    pad_in_i[3] = 1'b0; idle(5);
    wr(ca(3), 32'h101C);
    rd(ca(3), d); chk("R5 level gone stays clear", d, 32'h1C);
    // R5 level low
    wr(ca(3), 32'h0C); idle(2);
    rd(ca(3), d); chk("R5 level low", d, 32'h100C);
    pad_in_i[3] = 1'b1; idle(5);
    wr(ca(3), 32'h100C);
    rd(ca(3), d); chk("R5 level low released", d, 32'h200C);
    wr(ca(3), 32'h1000);
    pad_in_i[3] = 1'b0; idle(5);

    // R7 writing 0 to bit12 keeps flag, R10 enable gating
    wr(ca(3), 32'h14);
    pad_in_i[3] = 1'b1; idle(5);
    wr(ca(3), 32'h14);
    rd(ca(3), d); chk("R7 zero write keeps flag", d, 32'h3014);
    wr(ca(3), 32'h10);
    rd(ca(3), d); chk("R10 flag kept when disabled", d, 32'h3010);
    chk("R10 irq off when disabled", 32'(irq_o), 32'h0);
    wr(ca(3), 32'h1000);
    pad_in_i[3] = 1'b0; idle(5);
    rd(ca(3), d); chk("R7 clean pin", d, 32'h0);

    // R8 summary words
    wr(ca(3), 32'h14);
    wr(ca(35), 32'h14);
    pad_in_i[3] = 1'b1; pad_in_i[35] = 1'b1; idle(5);
    rd(12'h100, d); chk("R8 word0 bit3", d, 32'h8);
    rd(12'h104, d); chk("R8 word1 bit3 for pin35", d, 32'h8);
    wr(12'h104, 32'h8);
    rd(12'h104, d); chk("R8 clear via word1", d, 32'h0);
    rd(ca(35), d); chk("R8 pin35 cleared", d, 32'h2014);
    rd(12'h100, d); chk("R8 word0 untouched", d, 32'h8);
    wr(12'h100, 32'h0);
    rd(12'h100, d); chk("R8 zero write no effect", d, 32'h8);
    wr(12'h100, 32'h8);
    rd(ca(3), d); chk("R8 pin3 cleared via word0", d, 32'h2014);
    chk("R10 irq idle", 32'(irq_o), 32'h0);
    pad_in_i[3] = 1'b0; pad_in_i[35] = 1'b0; idle(5);
    wr(ca(3), 32'h1000);
    wr(ca(35), 32'h1000);

    // R6 mask
    wr(ca(3), 32'h14);
    wr(ca(3), 32'h214);
    pad_in_i[3] = 1'b1; idle(8);
    rd(ca(3), d); chk("R6 masked frozen no flag", d, 32'h214);
    chk("R6 no irq while masked", 32'(irq_o), 32'h0);
    wr(ca(3), 32'h14); idle(6);
    rd(ca(3), d); chk("R6 unmasked updates", d, 32'h3014);
    wr(ca(3), 32'h1000);
    pad_in_i[3] = 1'b0; idle(5);

    // R9 debounce: 2**code samples pass, one fewer is rejected
    for (int c = 0; c < 4; c++) begin
      wr(ca(4), 32'h14 | (32'(c) << 7));
      if (c > 0) begin
        pulse(4, (1 << c) - 1); idle(16);
        rd(ca(4), d); chk($sformatf("R9 short pulse code %0d", c), d & 32'h3000, 32'h0);
      end
      pulse(4, 1 << c); idle(16);
      rd(ca(4), d); chk($sformatf("R9 full pulse code %0d", c), d & 32'h3000, 32'h1000);
      wr(ca(4), 32'h1000);
    end

    // R3 unmapped and misaligned
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h17C, 32'hFFFF_FFFF);
    wr(12'h181, 32'h0);
    rd(ca(0), d);   chk("R3 stray writes ignored", d, 32'h2003);
    rd(12'h000, d); chk("R3 unmapped read", d, 32'h0);
    rd(12'h108, d); chk("R3 past summary read", d, 32'h0);
    rd(ca(NP), d);  chk("R3 past pins read", d, 32'h0);
    rd(12'h181, d); chk("R3 misaligned read", d, 32'h0);

    summary();
    $finish;
  end

endmodule